// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address that one RAM port uses for each access. A client can present an address of its own, or let the block step through consecutive locations with an internal counter. Every clock, four controls are sampled on the rising edge: an external address, an active-low strobe, an active-low count enable and an active-low synchronous clear. Each cycle the block settles on one of four actions. It clears, loads, advances or holds. The address for the access leaves the block in the same cycle as the controls that select it.

The counter keeps the address the access used and takes it as its value at the rising edge. A clear therefore returns zero in its own cycle, and the first advance after it returns one, so a clear costs no extra cycle. The counter has the width of the RAM address and wraps from the top location back to zero. It takes no chip-select input of any kind. An asynchronous active-low system reset also forces the counter to zero.

Top module: `burst_addr_gen`

## Requirements
- R1: While `cnt_clr_n` is 0, `acc_addr` is 0 in that cycle and the counter holds 0 after the edge, whatever the strobe, enable and external address are.
- R2: While `cnt_clr_n` is 1 and `strobe_n` is 0, `acc_addr` equals `ext_addr` in the same cycle, and the counter takes that value at the edge.
- R3: While `cnt_clr_n` and `strobe_n` are 1 and `cnt_en_n` is 0, `acc_addr` is the counter value plus one, and the counter takes that value at the edge.
- R4: While `cnt_clr_n`, `strobe_n` and `cnt_en_n` are all 1, `acc_addr` equals the counter value, the counter keeps its value, and `ext_addr` has no effect.
- R5: `cnt_en_n` has no effect while either `cnt_clr_n` or `strobe_n` is 0.
- R6: An advance from the all-ones address yields 0, since the arithmetic is modulo 2^AW.
- R7: After a clear cycle, the next advancing cycle uses address 1.
- R8: While `rst_n` is 0 the counter is forced to 0 without waiting for a clock edge, so the first hold cycle after release shows 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ext_addr | input | AW | Address supplied by the client |
| strobe_n | input | 1 | Active low; passes `ext_addr` through and loads it into the counter |
| cnt_en_n | input | 1 | Active low; advances the counter by one |
| cnt_clr_n | input | 1 | Active low; synchronous clear to zero, highest priority |
| acc_addr | output | AW | Address used by the access in this cycle |

## Verification
`acc_addr` is combinational from the controls and the counter register. It is therefore due in the same cycle as its stimulus. The counter's new value only shows one rising edge later, through the address of a following hold or advance cycle. The bench drives inputs on the falling edge and samples `acc_addr` 2 ns later, before the next rising edge. Every check of a state update is made in the cycle after the edge that should have written it. A hold cycle reads the stored value back through the port without changing it.

// File: rtl/bag_pkg.sv
package bag_pkg;
    typedef enum logic [1:0] {
        MODE_CLEAR   = 2'd0,
        MODE_LOAD    = 2'd1,
        MODE_ADVANCE = 2'd2,
        MODE_HOLD    = 2'd3
    } bag_mode_e;
endpackage

// File: rtl/bag_prio.sv
module bag_prio
    import bag_pkg::*;
(
    input  logic      strobe_n,
    input  logic      cnt_en_n,
    input  logic      cnt_clr_n,
    output bag_mode_e mode
);
    // Clear wins over load, load wins over advance.
    always_comb begin
        if (!cnt_clr_n)      mode = MODE_CLEAR;
        else if (!strobe_n)  mode = MODE_LOAD;
        else if (!cnt_en_n)  mode = MODE_ADVANCE;
        else                 mode = MODE_HOLD;
    end
endmodule

// File: rtl/bag_next.sv
module bag_next
    import bag_pkg::*;
#(
    parameter int AW = 13
) (
    input  bag_mode_e         mode,
    input  logic [AW-1:0]     ext_addr,
    input  logic [AW-1:0]     cnt_q,
    output logic [AW-1:0]     addr
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_comb begin
        unique case (mode)
            MODE_CLEAR:   addr = '0;
            MODE_LOAD:    addr = ext_addr;
            MODE_ADVANCE: addr = cnt_q + ONE;
            default:      addr = cnt_q;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ext_addr,
    input  logic          strobe_n,
    input  logic          cnt_en_n,
    input  logic          cnt_clr_n,
    output logic [AW-1:0] acc_addr
);
    typedef struct packed {
        logic [AW-1:0] cnt;
    } state_t;

    state_t        st_d, st_q;
    bag_mode_e     mode;
    logic [AW-1:0] addr_w;

    bag_prio u_prio (
        .strobe_n  (strobe_n),
        .cnt_en_n  (cnt_en_n),
        .cnt_clr_n (cnt_clr_n),
        .mode      (mode)
    );

    bag_next #(.AW(AW)) u_next (
        .mode     (mode),
        .ext_addr (ext_addr),
        .cnt_q    (st_q.cnt),
        .addr     (addr_w)
    );

    // The counter keeps the address the current access used.
    always_comb begin
        st_d     = st_q;
        st_d.cnt = addr_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_addr = addr_w;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] ext_addr,
    input logic          strobe_n,
    input logic          cnt_en_n,
    input logic          cnt_clr_n,
    input logic [AW-1:0] acc_addr,
    input logic [AW-1:0] cnt_q
);
    a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr_n |-> acc_addr == '0);

    a_r1_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr_n |=> cnt_q == '0);

    a_r2_strobe_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr_n && !strobe_n) |-> acc_addr == ext_addr);

    a_r2_strobe_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr_n && !strobe_n) |=> cnt_q == $past(ext_addr));

    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr_n && strobe_n && !cnt_en_n) |-> acc_addr == AW'(cnt_q + AW'(1)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr_n && strobe_n && cnt_en_n) |=> $stable(cnt_q));

    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr_n && strobe_n && !cnt_en_n && (&cnt_q)) |-> acc_addr == '0);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_addr  (ext_addr),
    .strobe_n  (strobe_n),
    .cnt_en_n  (cnt_en_n),
    .cnt_clr_n (cnt_clr_n),
    .acc_addr  (acc_addr),
    .cnt_q     (st_q.cnt)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
    localparam int AW = 13;
    localparam logic [AW-1:0] TOP = {AW{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          strobe_n = 1'b1;
    logic          cnt_en_n = 1'b1;
    logic          cnt_clr_n = 1'b1;
    logic [AW-1:0] acc_addr;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    burst_addr_gen #(.AW(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_addr  (ext_addr),
        .strobe_n  (strobe_n),
        .cnt_en_n  (cnt_en_n),
        .cnt_clr_n (cnt_clr_n),
        .acc_addr  (acc_addr)
    );

    // Drive one cycle at the falling edge, check acc_addr 2 ns later.
    task automatic cyc(input logic clr, input logic str, input logic en,
                       input logic [AW-1:0] ext, input logic [AW-1:0] exp,
                       input string req);
        @(negedge clk);
        cnt_clr_n = clr;
        strobe_n  = str;
        cnt_en_n  = en;
        ext_addr  = ext;
        #2;
        total++;
        if (acc_addr !== exp) begin
            bad++;
            $display("FAIL %s: acc_addr=%h expected=%h", req, acc_addr, exp);
        end
    endtask

    task automatic t_reset_state();
        cyc(1, 1, 1, 13'h0ABC, 13'h0000, "R8 reset hold");
    endtask

    task automatic t_load_hold_advance();
        cyc(1, 0, 1, 13'h0123, 13'h0123, "R2 load pass");
        cyc(1, 1, 1, 13'h1F00, 13'h0123, "R4 hold ignores ext");
        cyc(1, 1, 0, 13'h0777, 13'h0124, "R3 advance 1");
        cyc(1, 1, 0, 13'h0000, 13'h0125, "R3 advance 2");
        cyc(1, 1, 1, 13'h0555, 13'h0125, "R4 hold after advance");
    endtask

    task automatic t_enable_masked();
        cyc(1, 0, 0, 13'h0A0A, 13'h0A0A, "R5 strobe masks enable");
        cyc(1, 1, 1, 13'h0000, 13'h0A0A, "R5 loaded not advanced");
        cyc(0, 0, 0, 13'h0B0B, 13'h0000, "R1 clear overrides");
        cyc(1, 1, 1, 13'h0B0B, 13'h0000, "R1 R5 counter zero");
    endtask

    task automatic t_clear_then_advance();
        cyc(1, 0, 1, 13'h0042, 13'h0042, "R2 load before clear");
        cyc(0, 1, 0, 13'h0042, 13'h0000, "R1 clear with enable");
        cyc(1, 1, 0, 13'h0042, 13'h0001, "R7 first advance");
        cyc(1, 1, 0, 13'h0042, 13'h0002, "R7 second advance");
    endtask

    task automatic t_wrap();
        cyc(1, 0, 1, TOP, TOP, "R2 load top");
        cyc(1, 1, 0, 13'h0000, 13'h0000, "R6 wrap to zero");
        cyc(1, 1, 0, 13'h0000, 13'h0001, "R6 after wrap");
    endtask

    task automatic t_async_reset();
        cyc(1, 0, 1, 13'h0055, 13'h0055, "R2 load before reset");
        @(negedge clk);
        cnt_clr_n = 1'b1; strobe_n = 1'b1; cnt_en_n = 1'b1;
        #1 rst_n = 1'b0;
        #2;
        total++;
        if (acc_addr !== '0) begin
            bad++;
            $display("FAIL R8 async clear: acc_addr=%h expected=%h", acc_addr, 13'h0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1, 1, 1, 13'h0055, 13'h0000, "R8 after release");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_load_hold_advance();
        t_enable_masked();
        t_clear_then_advance();
        t_wrap();
        t_async_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule